// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a host bus and the write state machine of a flash device. It turns bus write cycles into one-cycle and two-cycle flash commands and remembers which setup code is waiting for its second cycle. When a command is complete, it emits a one-cycle start pulse that carries an operation code, an address and a data word. The write state machine reports the end of a long operation with a done pulse. Erase and program operations can be suspended and resumed. The block also streams buffered-program words out to the program buffer.

An 8-bit status word is always visible:
- bit 7 is ready.
- bit 6 is erase-suspended.
- bits 5 and 4 together flag a command-sequence error.
- bit 2 is program-suspended.
- bits 3, 1 and 0 read zero.

A read-mode output tells the read path whether to return array data (0) or the status word (1). A configuration value loaded by a dedicated two-cycle command is held on its own output.

The command code is the low 8 bits of the write data. Writes are accepted on every cycle in which `wr_en` is high. There is no back-pressure. The effect of a write appears on the outputs right after the clock edge that samples it.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset (active-low `rst_n`) the block is in its idle state with no pending setup and no suspend. The outputs are as follows:
  - `status` reads 0x80.
  - `read_mode` is 0 (array).
  - `rd_cfg` is 0.
  - No pulse output is high.
- R2: A write of 0x20 followed by a write of 0xD0 at address A gives a start pulse with `start_op`=3 (erase) and `op_addr`=A. After that pulse, ready reads 0 and `read_mode` reads 1 until `wsm_done`.
- R3: If erase setup (0x20) is followed by any code other than 0xD0, no start pulse is issued. Status bits 5 and 4 are set, `read_mode` becomes 1 and the block returns to idle.
- R4: While an operation runs, only 0x70 (status read mode) and 0xB0 (suspend) act. Every other code is ignored: no start pulse and no status change.
- R5: 0xB0 during a running erase, word program or buffered program gives a `wsm_suspend` pulse. Status then reads ready plus bit 6 for an erase, or ready plus bit 2 for a program. Protection programs and factory-program mode cannot be suspended.
- R6: While suspended, `wsm_done` is ignored and every code except 0xD0, 0x70 and 0xFF is ignored. A 0xD0 gives a `wsm_resume` pulse, clears the suspend bit and returns to the running state with ready at 0.
- R7: A buffered program runs as the following sequence of writes:
  - 0xE8 starts it.
  - The next write carries the word count minus one in data bits 4:0 (up to 32 words).
  - Each of the following that many writes gives a `buf_we` pulse, with `buf_idx` counting from 0 and `buf_data` equal to the write data.
  - A final 0xD0 at address A gives a start pulse with `start_op`=2, `op_addr`=A and `op_data` equal to the count minus one.
  - Any other final code is a sequence error, as in R3.
- R8: 0x80 followed by 0xD0 gives a start pulse with `start_op`=6 and enters factory-program mode. Every write is ignored there until `wsm_done`. 0x80 followed by any other code is a sequence error.
- R9: 0x60 followed by 0x03 at address A loads A[15:0] into `rd_cfg`, sets `read_mode` to 0 and issues no start pulse.
- R10: 0x60 followed by 0x01, 0xD0 or 0x2F gives a start pulse with `start_op`=4 and `op_data` equal to that code. The block does not wait for `wsm_done` and ready stays 1. Any other second code is a sequence error.
- R11: Setup with 0x40 or 0x10, followed by any write, gives `start_op`=1 with that write's address and data. Setup with 0xC0, followed by any write, gives `start_op`=5. Each of these runs until `wsm_done`, after which status reads 0x80.
- R12: 0x50 written in idle clears status bits 5 to 1.
- R13: In idle or suspend, 0x70 sets `read_mode` to 1 and 0xFF sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | AW (24) | Write address |
| wr_data | input | DW (16) | Write data; low 8 bits are the command code |
| wsm_done | input | 1 | Write state machine finished the running operation |
| start_valid | output | 1 | One-cycle start pulse to the write state machine |
| start_op | output | 3 | Operation: 1 word, 2 buffer, 3 erase, 4 lock, 5 protection, 6 factory |
| op_addr | output | AW | Address latched with the start |
| op_data | output | DW | Data latched with the start |
| wsm_suspend | output | 1 | One-cycle suspend request |
| wsm_resume | output | 1 | One-cycle resume request |
| buf_we | output | 1 | Program buffer write pulse |
| buf_idx | output | 5 | Program buffer word index |
| buf_data | output | DW | Program buffer word |
| read_mode | output | 1 | 0 array data, 1 status word |
| status | output | 8 | Status register |
| rd_cfg | output | 16 | Read configuration value |

## Verification
The hardest state to reach is a suspended erase under hostile input. The block must first be driven through a valid erase pair and then suspended. After that, stray setup codes, clear-status and `wsm_done` are applied, and none of them may move it. The bench reaches this by issuing 0x20/0xD0, then sweeping every one of the 256 codes through the running state before the suspend. It then injects codes and a done pulse while suspended. It also sweeps all 256 codes as the second cycle after the erase setup and after the lock/configuration setup, and it streams both the smallest and the largest buffer.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    C_NONE, C_WORD, C_BUF, C_ERASE, C_EFP, C_LOCKCFG, C_PROT, C_CONFIRM,
    C_SUSPEND, C_RDSTAT, C_RDARR, C_CLRSTAT, C_LOCK, C_LOCKDN, C_CFGSET
  } cmd_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_WORD = 3'd1, OP_BUF = 3'd2, OP_ERASE = 3'd3,
    OP_LOCK = 3'd4, OP_PROT = 3'd5, OP_EFP = 3'd6
  } op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PEND, S_BUF_CNT, S_BUF_DATA, S_BUF_CONF, S_BUSY, S_SUSP, S_EFP
  } seq_st_t;

  localparam logic RM_ARRAY  = 1'b0;
  localparam logic RM_STATUS = 1'b1;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);
  always_comb begin
    case (code)
      8'h40, 8'h10: cmd = C_WORD;
      8'hE8:        cmd = C_BUF;
      8'h20:        cmd = C_ERASE;
      8'h80:        cmd = C_EFP;
      8'h60:        cmd = C_LOCKCFG;
      8'hC0:        cmd = C_PROT;
      8'hD0:        cmd = C_CONFIRM;
      8'hB0:        cmd = C_SUSPEND;
      8'h70:        cmd = C_RDSTAT;
      8'hFF:        cmd = C_RDARR;
      8'h50:        cmd = C_CLRSTAT;
      8'h01:        cmd = C_LOCK;
      8'h2F:        cmd = C_LOCKDN;
      8'h03:        cmd = C_CFGSET;
      default:      cmd = C_NONE;
    endcase
  end
endmodule

// File: rtl/fcs_regs.sv
module fcs_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_set,
  input  logic        clr_req,
  input  logic        ready,
  input  logic        susp_erase,
  input  logic        susp_prog,
  input  logic        cfg_we,
  input  logic [15:0] cfg_val,
  output logic [7:0]  status,
  output logic [15:0] rcr
);
  logic seq_err_q, cmd_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_err_q <= 1'b0;
      cmd_err_q <= 1'b0;
      rcr       <= '0;
    end else begin
      if (clr_req) begin
        seq_err_q <= 1'b0;
        cmd_err_q <= 1'b0;
      end else if (err_set) begin
        seq_err_q <= 1'b1;
        cmd_err_q <= 1'b1;
      end
      if (cfg_we) rcr <= cfg_val;
    end
  end

  assign status = {ready, susp_erase, seq_err_q, cmd_err_q, 1'b0, susp_prog, 1'b0, 1'b0};

  a_r3_err_bits: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> (status[5] && status[4]));
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (status[5:1] == 5'd0));
  a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (rcr == $past(cfg_val)));
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int BUF_WORDS = 32,
  localparam int IW = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  cmd_t          cmd,
  input  logic          wsm_done,
  output logic          start_valid,
  output logic [2:0]    start_op,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          wsm_suspend,
  output logic          wsm_resume,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [DW-1:0] buf_data,
  output logic          read_mode,
  output logic          err_set,
  output logic          clr_req,
  output logic          cfg_we,
  output logic [15:0]   cfg_val,
  output logic          ready,
  output logic          susp_erase,
  output logic          susp_prog
);
  seq_st_t       st_q;
  op_t           pend_q, run_q, op_q;
  logic [IW-1:0] idx_q, last_q;
  logic          lock_code, confirm, suspendable;

  assign confirm     = (cmd == C_CONFIRM);
  assign lock_code   = (cmd == C_LOCK) || (cmd == C_CONFIRM) || (cmd == C_LOCKDN);
  assign suspendable = (run_q == OP_WORD) || (run_q == OP_BUF) || (run_q == OP_ERASE);

  always_comb begin
    err_set = 1'b0;
    if (wr_en) begin
      if (st_q == S_PEND) begin
        if ((pend_q == OP_ERASE || pend_q == OP_EFP) && !confirm) err_set = 1'b1;
        if (pend_q == OP_LOCK && !lock_code && cmd != C_CFGSET)  err_set = 1'b1;
      end
      if (st_q == S_BUF_CONF && !confirm) err_set = 1'b1;
    end
  end

  assign clr_req = wr_en && (st_q == S_IDLE) && (cmd == C_CLRSTAT);
  assign cfg_we  = wr_en && (st_q == S_PEND) && (pend_q == OP_LOCK) && (cmd == C_CFGSET);
  assign cfg_val = wr_addr[15:0];

  assign ready      = (st_q != S_BUSY) && (st_q != S_EFP);
  assign susp_erase = (st_q == S_SUSP) && (run_q == OP_ERASE);
  assign susp_prog  = (st_q == S_SUSP) && (run_q != OP_ERASE);
  assign start_op   = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      pend_q      <= OP_NONE;
      run_q       <= OP_NONE;
      op_q        <= OP_NONE;
      idx_q       <= '0;
      last_q      <= '0;
      start_valid <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      wsm_suspend <= 1'b0;
      wsm_resume  <= 1'b0;
      buf_we      <= 1'b0;
      buf_idx     <= '0;
      buf_data    <= '0;
      read_mode   <= RM_ARRAY;
    end else begin
      start_valid <= 1'b0;
      wsm_suspend <= 1'b0;
      wsm_resume  <= 1'b0;
      buf_we      <= 1'b0;
      if (err_set) begin
        read_mode <= RM_STATUS;
        st_q      <= S_IDLE;
      end else begin
        case (st_q)
          S_IDLE: if (wr_en) begin
            case (cmd)
              C_WORD:    begin pend_q <= OP_WORD;  st_q <= S_PEND; end
              C_ERASE:   begin pend_q <= OP_ERASE; st_q <= S_PEND; end
              C_LOCKCFG: begin pend_q <= OP_LOCK;  st_q <= S_PEND; end
              C_PROT:    begin pend_q <= OP_PROT;  st_q <= S_PEND; end
              C_EFP:     begin pend_q <= OP_EFP;   st_q <= S_PEND; end
              C_BUF:     st_q <= S_BUF_CNT;
              C_RDSTAT:  read_mode <= RM_STATUS;
              C_RDARR:   read_mode <= RM_ARRAY;
              default: ;
            endcase
          end
          S_PEND: if (wr_en) begin
            if (pend_q == OP_LOCK) begin
              if (cmd == C_CFGSET) begin
                read_mode <= RM_ARRAY;
              end else begin
                start_valid <= 1'b1;
                op_q        <= OP_LOCK;
                op_addr     <= wr_addr;
                op_data     <= wr_data;
                read_mode   <= RM_STATUS;
              end
              st_q <= S_IDLE;
            end else begin
              start_valid <= 1'b1;
              op_q        <= pend_q;
              run_q       <= pend_q;
              op_addr     <= wr_addr;
              op_data     <= wr_data;
              read_mode   <= RM_STATUS;
              st_q        <= (pend_q == OP_EFP) ? S_EFP : S_BUSY;
            end
          end
          S_BUF_CNT: if (wr_en) begin
            last_q <= wr_data[IW-1:0];
            idx_q  <= '0;
            st_q   <= S_BUF_DATA;
          end
          S_BUF_DATA: if (wr_en) begin
            buf_we   <= 1'b1;
            buf_idx  <= idx_q;
            buf_data <= wr_data;
            if (idx_q == last_q) st_q <= S_BUF_CONF;
            else idx_q <= idx_q + 1'b1;
          end
          S_BUF_CONF: if (wr_en) begin
            start_valid <= 1'b1;
            op_q        <= OP_BUF;
            run_q       <= OP_BUF;
            op_addr     <= wr_addr;
            op_data     <= {{(DW-IW){1'b0}}, last_q};
            read_mode   <= RM_STATUS;
            st_q        <= S_BUSY;
          end
          S_BUSY: begin
            if (wr_en && cmd == C_RDSTAT) read_mode <= RM_STATUS;
            if (wsm_done) st_q <= S_IDLE;
            else if (wr_en && cmd == C_SUSPEND && suspendable) begin
              wsm_suspend <= 1'b1;
              st_q        <= S_SUSP;
            end
          end
          S_SUSP: if (wr_en) begin
            case (cmd)
              C_CONFIRM: begin wsm_resume <= 1'b1; st_q <= S_BUSY; end
              C_RDSTAT:  read_mode <= RM_STATUS;
              C_RDARR:   read_mode <= RM_ARRAY;
              default: ;
            endcase
          end
          S_EFP: if (wsm_done) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  a_r4_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY) |=> !start_valid);
  a_r5_suspend_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY && wr_en && cmd == C_SUSPEND && suspendable && !wsm_done)
      |=> (wsm_suspend && st_q == S_SUSP));
  a_r6_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SUSP && !(wr_en && cmd == C_CONFIRM)) |=> (st_q == S_SUSP));
  a_r8_efp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EFP) |=> (!start_valid && !wsm_suspend && !buf_we));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int BUF_WORDS = 32,
  localparam int IW = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wsm_done,
  output logic          start_valid,
  output logic [2:0]    start_op,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          wsm_suspend,
  output logic          wsm_resume,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [DW-1:0] buf_data,
  output logic          read_mode,
  output logic [7:0]    status,
  output logic [15:0]   rd_cfg
);
  cmd_t        cmd;
  logic        err_set, clr_req, cfg_we, ready, susp_erase, susp_prog;
  logic [15:0] cfg_val;

  fcs_decode u_dec (.code(wr_data[7:0]), .cmd(cmd));

  fcs_seq #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS)) u_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cmd, .wsm_done,
    .start_valid, .start_op, .op_addr, .op_data, .wsm_suspend, .wsm_resume,
    .buf_we, .buf_idx, .buf_data, .read_mode, .err_set, .clr_req, .cfg_we,
    .cfg_val, .ready, .susp_erase, .susp_prog
  );

  fcs_regs u_regs (
    .clk, .rst_n, .err_set, .clr_req, .ready, .susp_erase, .susp_prog,
    .cfg_we, .cfg_val, .status, .rcr(rd_cfg)
  );
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wsm_done = 1'b0;
  logic        start_valid, wsm_suspend, wsm_resume, buf_we, read_mode;
  logic [2:0]  start_op;
  logic [23:0] op_addr;
  logic [15:0] op_data, buf_data, rd_cfg;
  logic [4:0]  buf_idx;
  logic [7:0]  status;
  int vecs = 0;
  int miss = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_seq u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wsm_done, .start_valid,
    .start_op, .op_addr, .op_data, .wsm_suspend, .wsm_resume, .buf_we,
    .buf_idx, .buf_data, .read_mode, .status, .rd_cfg
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d, input logic [23:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    wsm_done = 1'b1;
    @(negedge clk);
    wsm_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 status", status, 8'h80);
    chk("R1 read_mode", read_mode, 0);
    chk("R1 rd_cfg", rd_cfg, 0);
    chk("R1 pulses", {start_valid, wsm_suspend, wsm_resume, buf_we}, 0);

    // R2 erase, then R4 busy sweep, R5 suspend, R6 resume
    put(16'h20, 0);
    put(16'hD0, 24'h1234);
    chk("R2 start", start_valid, 1);
    chk("R2 op", start_op, 3);
    chk("R2 addr", op_addr, 24'h1234);
    chk("R2 status busy", status, 8'h00);
    chk("R2 read_mode", read_mode, 1);
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hB0) continue;
      put(16'(c), 24'(c));
      chk("R4 no start in busy", {start_valid, wsm_suspend}, 0);
      chk("R4 status unchanged", status, 8'h00);
    end
    put(16'hB0, 24'h7);
    chk("R5 suspend pulse", wsm_suspend, 1);
    chk("R5 erase suspended", status, 8'hC0);
    put(16'h20, 0);
    put(16'h50, 0);
    done_pulse();
    chk("R6 held through noise", status, 8'hC0);
    put(16'hFF, 0);
    chk("R13 array in suspend", read_mode, 0);
    put(16'h70, 0);
    chk("R13 status in suspend", read_mode, 1);
    put(16'hD0, 0);
    chk("R6 resume pulse", wsm_resume, 1);
    chk("R6 resumed status", status, 8'h00);
    done_pulse();
    chk("R2 done ready", status, 8'h80);

    // R3 second-cycle sweep after erase setup
    for (int c = 0; c < 256; c++) begin
      put(16'h20, 0);
      put(16'(c), 24'h40 + 24'(c));
      if (c == 8'hD0) begin
        chk("R2 sweep start", {start_valid, start_op}, {1'b1, 3'd3});
        done_pulse();
        chk("R2 sweep done", status, 8'h80);
      end else begin
        chk("R3 no start", start_valid, 0);
        chk("R3 error bits", status, 8'hB0);
        chk("R3 read_mode", read_mode, 1);
        put(16'h50, 0);
        chk("R12 cleared", status, 8'h80);
      end
    end

    // R9 / R10 sweep after 0x60
    for (int c = 0; c < 256; c++) begin
      put(16'h60, 24'hA000);
      put(16'(c), 24'h5A00 + 24'(c));
      if (c == 8'h01 || c == 8'hD0 || c == 8'h2F) begin
        chk("R10 lock start", {start_valid, start_op}, {1'b1, 3'd4});
        chk("R10 lock code", op_data, 16'(c));
        chk("R10 ready kept", status, 8'h80);
      end else if (c == 8'h03) begin
        chk("R9 no start", start_valid, 0);
        chk("R9 rd_cfg", rd_cfg, 16'h5A03);
        chk("R9 read_mode", read_mode, 0);
      end else begin
        chk("R10 bad second", status, 8'hB0);
        put(16'h50, 0);
      end
    end

    // R11 word program (both setup codes), suspend
    for (int k = 0; k < 2; k++) begin
      put(k == 0 ? 16'h40 : 16'h10, 24'h100);
      put(16'hBEEF - 16'(k), 24'h200 + 24'(k));
      chk("R11 word op", {start_valid, start_op}, {1'b1, 3'd1});
      chk("R11 word addr", op_addr, 24'h200 + 24'(k));
      chk("R11 word data", op_data, 16'hBEEF - 16'(k));
      put(16'hB0, 0);
      chk("R5 program suspended", status, 8'h84);
      put(16'hD0, 0);
      chk("R6 program resumed", status, 8'h00);
      done_pulse();
      chk("R11 done", status, 8'h80);
    end
    put(16'hC0, 0);
    put(16'h1111, 24'h80);
    chk("R11 prot op", {start_valid, start_op}, {1'b1, 3'd5});
    put(16'hB0, 0);
    chk("R5 prot not suspendable", {wsm_suspend, status}, {1'b0, 8'h00});
    done_pulse();
    chk("R11 prot done", status, 8'h80);

    // R7 buffered program, smallest and largest
    for (int n = 1; n <= 32; n += 31) begin
      put(16'hE8, 0);
      put(16'(n - 1), 0);
      for (int i = 0; i < n; i++) begin
        put(16'h3000 + 16'(i), 0);
        chk("R7 buf_we", buf_we, 1);
        chk("R7 buf_idx", buf_idx, i);
        chk("R7 buf_data", buf_data, 16'h3000 + 16'(i));
      end
      put(16'hD0, 24'h300);
      chk("R7 start", {start_valid, start_op}, {1'b1, 3'd2});
      chk("R7 count", op_data, n - 1);
      chk("R7 addr", op_addr, 24'h300);
      done_pulse();
    end
    put(16'hE8, 0);
    put(16'd2, 0);
    for (int i = 0; i < 3; i++) put(16'(i), 0);
    put(16'h40, 0);
    chk("R7 bad confirm", {start_valid, status}, {1'b0, 8'hB0});
    put(16'h50, 0);

    // R8 factory program mode
    put(16'h80, 0);
    put(16'hD0, 24'h9);
    chk("R8 start", {start_valid, start_op}, {1'b1, 3'd6});
    put(16'hB0, 0);
    put(16'h20, 0);
    put(16'hD0, 0);
    chk("R8 ignored", {start_valid, wsm_suspend, status}, {2'b00, 8'h00});
    done_pulse();
    chk("R8 done", status, 8'h80);
    put(16'h80, 0);
    put(16'h40, 0);
    chk("R8 bad confirm", status, 8'hB0);
    put(16'h50, 0);

    // R13 read mode in idle
    put(16'hFF, 0);
    chk("R13 array", read_mode, 0);
    put(16'h70, 0);
    chk("R13 status", read_mode, 1);

    // R1 reset while suspended
    put(16'h20, 0);
    put(16'hD0, 0);
    put(16'hB0, 0);
    do_reset();
    chk("R1 reset clears suspend", {status, read_mode, rd_cfg}, {8'h80, 1'b0, 16'h0});

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule